// File: doc/BRIEF.md
# Colour Palette Register Port

This block is the host-facing register port of a video colour palette. It keeps two lookup tables: a main table of 256 entries and an overlay table of 16 entries. Every entry is a red, green, blue byte triplet. The host talks to it over a byte-wide synchronous register bus. To reach an entry, the host first loads a read or write pointer. It then moves colour bytes one at a time through a data register.

A phase counter per table decides which colour byte each data access moves, in the order red, green, blue. After the third byte of a triplet, the pointer steps to the next entry by itself. A write triplet is committed to the table only when the colour-mode input is high. In monochrome mode the sequencing still runs, but the table keeps its contents. Register offsets that are not data registers act as plain byte registers, so the host can read back the last byte it wrote there.

Top module: `pal_regport`

## Requirements
- R1: After reset, every non-data offset reads 0x00, and both tables start at pointer 0, phase 0. Three data writes with no pointer load therefore fill entry 0.
- R2: Writing the main write-pointer register (offset 0x0) loads the write pointer from the byte and sets the main phase to 0. The overlay write-pointer register (offset 0x4) does the same for the overlay table.
- R3: Each write to the main data register (offset 0x2) stores one colour byte, in the order red, green, blue. The third byte commits the triplet to the entry at the write pointer, then the pointer increments by one.
- R4: Writing the main read-pointer register (offset 0x1) loads the read pointer and sets the phase to 0. Successive data reads then return red, green, blue of that entry and then continue with the next entry. A read at phase 0 fetches the entry fresh from the table.
- R5: Read data appears on bus_rdata in the cycle after the read strobe. It holds its value through cycles that carry no read.
- R6: While color_en is low, a completed write triplet leaves the table unchanged, but the phase and the write pointer still advance.
- R7: The overlay table (pointer registers 0x4 write and 0x5 read, data register 0x6) has its own pointers, phase and holding triplet. Overlay accesses never disturb the main sequence, and main accesses never disturb the overlay sequence.
- R8: Overlay pointers take the low 4 bits of a loaded byte. They wrap from 15 to 0 on increment.
- R9: Main read and write pointers wrap from 255 to 0 on increment.
- R10: A read of a pointer register returns the byte last written there, not the live pointer. All other non-data offsets (0x3, 0x7 to 0xF) are plain read/write byte registers.
- R11: Loading either main pointer register in the middle of a triplet restarts the phase at 0. The partial write triplet is dropped, and the next data read fetches a new entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| color_en | input | 1 | High: colour mode, commits allowed; low: monochrome, commits blocked |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |

## Verification
The third data write of a triplet does two things in one cycle: it commits the triplet and it steps the pointer. On the last overlay entry that step is also a wrap to 0. The bench provokes this by writing two triplets across entry 15 and then reading both entries back in order. In monochrome mode the same cycle must step the pointer without committing. That is judged by the older data surviving and the next colour-mode triplet landing two entries further on. A read at phase 0 likewise fetches and returns a byte in one access, which is checked immediately after a commit to that entry.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OFS_W  = 4;
  localparam int unsigned NSLOT  = 1 << OFS_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [OFS_W-1:0]  ofs_t;

  localparam ofs_t OFS_MAIN_WPTR = 4'h0;
  localparam ofs_t OFS_MAIN_RPTR = 4'h1;
  localparam ofs_t OFS_MAIN_DATA = 4'h2;
  localparam ofs_t OFS_OVL_WPTR  = 4'h4;
  localparam ofs_t OFS_OVL_RPTR  = 4'h5;
  localparam ofs_t OFS_OVL_DATA  = 4'h6;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef struct packed {
    byte_t red;
    byte_t green;
    byte_t blue;
  } rgb_t;

  function automatic byte_t pick_byte(input rgb_t t, input phase_e p);
    case (p)
      PH_RED:   return t.red;
      PH_GREEN: return t.green;
      default:  return t.blue;
    endcase
  endfunction

endpackage

// File: rtl/pal_bank.sv
module pal_bank
  import pal_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             color_en,
  input  logic             ld_wptr,
  input  logic             ld_rptr,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  byte_t            wbyte,
  output byte_t            rbyte,
  output phase_e           phase_o,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] rptr_o
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rgb_t             mem [DEPTH];
  phase_e           phase_q, phase_d;
  logic [PTR_W-1:0] wptr_q, wptr_d;
  logic [PTR_W-1:0] rptr_q, rptr_d;
  rgb_t             hold_q, hold_d;
  logic             commit;
  rgb_t             fetch;
  rgb_t             commit_val;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic phase_e next_phase(input phase_e p);
    case (p)
      PH_RED:   return PH_GREEN;
      PH_GREEN: return PH_BLUE;
      default:  return PH_RED;
    endcase
  endfunction

  assign fetch      = (phase_q == PH_RED) ? mem[rptr_q] : hold_q;
  assign rbyte      = pick_byte(fetch, phase_q);
  assign commit_val = '{red: hold_q.red, green: hold_q.green, blue: wbyte};

  always_comb begin
    phase_d = phase_q;
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    hold_d  = hold_q;
    commit  = 1'b0;
    if (ld_wptr) begin
      wptr_d  = wbyte[PTR_W-1:0];
      phase_d = PH_RED;
    end else if (ld_rptr) begin
      rptr_d  = wbyte[PTR_W-1:0];
      phase_d = PH_RED;
    end else if (dat_wr) begin
      case (phase_q)
        PH_RED:   hold_d.red   = wbyte;
        PH_GREEN: hold_d.green = wbyte;
        default:  hold_d.blue  = wbyte;
      endcase
      phase_d = next_phase(phase_q);
      if (phase_q == PH_BLUE) begin
        commit = color_en;
        wptr_d = step(wptr_q);
      end
    end else if (dat_rd) begin
      hold_d  = fetch;
      phase_d = next_phase(phase_q);
      if (phase_q == PH_BLUE) begin
        rptr_d = step(rptr_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      wptr_q  <= '0;
      rptr_q  <= '0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      hold_q  <= hold_d;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      mem[wptr_q] <= commit_val;
    end
  end

  assign phase_o = phase_q;
  assign wptr_o  = wptr_q;
  assign rptr_o  = rptr_q;

endmodule

// File: rtl/pal_scratch.sv
module pal_scratch
  import pal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ofs_t  ofs,
  input  byte_t wbyte,
  output byte_t rbyte
);

  byte_t slot_q [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam ofs_t MY_OFS = ofs_t'(i);
    if (MY_OFS == OFS_MAIN_DATA || MY_OFS == OFS_OVL_DATA) begin : g_none
      assign slot_q[i] = '0;
    end else begin : g_reg
      byte_t q, d;
      logic  en;
      assign en = wr_en && (ofs == MY_OFS);
      always_comb d = en ? wbyte : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign slot_q[i] = q;
    end
  end

  assign rbyte = slot_q[ofs];

endmodule

// File: rtl/pal_regport.sv
module pal_regport
  import pal_pkg::*;
#(
  parameter int unsigned MAIN_DEPTH = 256,
  parameter int unsigned OVL_DEPTH  = 16,
  localparam int unsigned MPTR_W = $clog2(MAIN_DEPTH),
  localparam int unsigned OPTR_W = $clog2(OVL_DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       color_en,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  logic wr_stb, rd_stb;
  assign wr_stb = bus_sel &&  bus_we;
  assign rd_stb = bus_sel && !bus_we;

  byte_t main_byte, ovl_byte, scr_byte;
  phase_e main_phase, ovl_phase;
  logic [MPTR_W-1:0] main_wptr, main_rptr;
  logic [OPTR_W-1:0] ovl_wptr, ovl_rptr;

  pal_bank #(.DEPTH(MAIN_DEPTH)) i_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .color_en (color_en),
    .ld_wptr  (wr_stb && bus_addr == OFS_MAIN_WPTR),
    .ld_rptr  (wr_stb && bus_addr == OFS_MAIN_RPTR),
    .dat_wr   (wr_stb && bus_addr == OFS_MAIN_DATA),
    .dat_rd   (rd_stb && bus_addr == OFS_MAIN_DATA),
    .wbyte    (bus_wdata),
    .rbyte    (main_byte),
    .phase_o  (main_phase),
    .wptr_o   (main_wptr),
    .rptr_o   (main_rptr)
  );

  pal_bank #(.DEPTH(OVL_DEPTH)) i_ovl (
    .clk      (clk),
    .rst_n    (rst_n),
    .color_en (color_en),
    .ld_wptr  (wr_stb && bus_addr == OFS_OVL_WPTR),
    .ld_rptr  (wr_stb && bus_addr == OFS_OVL_RPTR),
    .dat_wr   (wr_stb && bus_addr == OFS_OVL_DATA),
    .dat_rd   (rd_stb && bus_addr == OFS_OVL_DATA),
    .wbyte    (bus_wdata),
    .rbyte    (ovl_byte),
    .phase_o  (ovl_phase),
    .wptr_o   (ovl_wptr),
    .rptr_o   (ovl_rptr)
  );

  pal_scratch i_scr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_stb),
    .ofs   (bus_addr),
    .wbyte (bus_wdata),
    .rbyte (scr_byte)
  );

  byte_t rd_sel, rd_q, rd_d;

  always_comb begin
    case (bus_addr)
      OFS_MAIN_DATA: rd_sel = main_byte;
      OFS_OVL_DATA:  rd_sel = ovl_byte;
      default:       rd_sel = scr_byte;
    endcase
    rd_d = rd_stb ? rd_sel : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

endmodule

// File: rtl/pal_regport_chk.sv
module pal_regport_chk
  import pal_pkg::*;
#(
  parameter int unsigned MPTR_W = 8,
  parameter int unsigned OPTR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [3:0]        bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input phase_e            main_phase,
  input phase_e            ovl_phase,
  input logic [MPTR_W-1:0] main_wptr,
  input logic [OPTR_W-1:0] ovl_wptr
);

  logic ovl_acc;
  assign ovl_acc = bus_sel && (bus_addr == OFS_OVL_WPTR || bus_addr == OFS_OVL_RPTR
                               || bus_addr == OFS_OVL_DATA);

  // R3: phase never reaches the unused code
  a_r3_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
    main_phase != 2'd3 && ovl_phase != 2'd3);

  // R2: pointer load takes the byte and restarts the phase
  a_r2_wptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_addr == OFS_MAIN_WPTR
    |=> main_phase == PH_RED && main_wptr == $past(bus_wdata));

  // R3: write pointer steps only on the blue byte
  a_r3_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_addr == OFS_MAIN_DATA && main_phase == PH_BLUE
    |=> main_wptr == MPTR_W'($past(main_wptr) + 1'b1));

  a_r3_wptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_addr == OFS_MAIN_DATA && main_phase != PH_BLUE
    |=> $stable(main_wptr));

  // R8: overlay write pointer wraps to zero
  a_r8_ovl_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && bus_addr == OFS_OVL_DATA && ovl_phase == PH_BLUE
    && ovl_wptr == OPTR_W'(15)
    |=> ovl_wptr == '0);

  // R5: read data holds when no read strobe
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> $stable(bus_rdata));

  // R7: overlay traffic leaves main sequence alone
  a_r7_main_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_acc |=> $stable(main_phase) && $stable(main_wptr));

endmodule

bind pal_regport pal_regport_chk #(.MPTR_W(MPTR_W), .OPTR_W(OPTR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .main_phase (main_phase),
  .ovl_phase  (ovl_phase),
  .main_wptr  (main_wptr),
  .ovl_wptr   (ovl_wptr)
);

// File: tb/test_pal_regport.sv
module test_pal_regport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       color_en = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  always #5 clk = ~clk;

  pal_regport i_pal_regport (
    .clk       (clk),
    .rst_n     (rst_n),
    .color_en  (color_en),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       rd_pend = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver tasks: called at a negedge, occupy one cycle
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr3(input logic [3:0] a, input logic [7:0] r, input logic [7:0] g,
                     input logic [7:0] b);
    wr(a, r); wr(a, g); wr(a, b);
  endtask

  task automatic rd3(input logic [3:0] a, input logic [7:0] r, input logic [7:0] g,
                     input logic [7:0] b, input string tag);
    rd(a, r, tag); rd(a, g, tag); rd(a, b, tag);
  endtask

  // monitor: a read strobe sampled at an edge is compared at the next negedge
  always @(posedge clk) rd_pend <= bus_sel && !bus_we;

  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R5 unexpected read data actual=%02h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [3:0] MW = 4'h0, MR = 4'h1, MD = 4'h2;
  localparam logic [3:0] OW = 4'h4, OR = 4'h5, OD = 4'h6;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(MW, 8'h00, "R1 wptr reg reset");
    rd(MR, 8'h00, "R1 rptr reg reset");
    rd(OW, 8'h00, "R1 ovl wptr reg reset");
    rd(4'h9, 8'h00, "R1 scratch reset");
    wr3(MD, 8'h11, 8'h22, 8'h33);
    wr(MR, 8'h00);
    rd3(MD, 8'h11, 8'h22, 8'h33, "R1 entry0 after reset");

    // R2 R3 R4: two triplets back to back
    wr(MW, 8'h10);
    wr3(MD, 8'hA1, 8'hA2, 8'hA3);
    wr3(MD, 8'hB1, 8'hB2, 8'hB3);
    wr(MR, 8'h10);
    rd3(MD, 8'hA1, 8'hA2, 8'hA3, "R3 R4 entry 0x10");
    rd3(MD, 8'hB1, 8'hB2, 8'hB3, "R3 R4 entry 0x11 after increment");

    // R10: pointer registers echo the stored byte
    rd(MW, 8'h10, "R10 wptr reg stored byte");
    rd(MR, 8'h10, "R10 rptr reg stored byte");

    // R11: mid-triplet pointer reload
    wr(MW, 8'h20);
    wr(MD, 8'h55); wr(MD, 8'h66);
    wr(MW, 8'h20);
    wr3(MD, 8'h77, 8'h88, 8'h99);
    wr(MR, 8'h20);
    rd3(MD, 8'h77, 8'h88, 8'h99, "R11 write phase restart");
    wr(MR, 8'h20);
    rd(MD, 8'h77, "R11 partial read");
    wr(MR, 8'h10);
    rd(MD, 8'hA1, "R11 read phase restart fetches new entry");

    // R6: monochrome blocks commits, pointer still advances
    color_en = 1'b0;
    wr(MW, 8'h10);
    wr3(MD, 8'hEE, 8'hEE, 8'hEE);
    wr3(MD, 8'hDD, 8'hDD, 8'hDD);
    color_en = 1'b1;
    wr3(MD, 8'hC1, 8'hC2, 8'hC3);
    wr(MR, 8'h10);
    rd3(MD, 8'hA1, 8'hA2, 8'hA3, "R6 mono left 0x10");
    rd3(MD, 8'hB1, 8'hB2, 8'hB3, "R6 mono left 0x11");
    rd3(MD, 8'hC1, 8'hC2, 8'hC3, "R6 pointer advanced in mono");

    // R9: main wrap
    wr(MW, 8'hFF);
    wr3(MD, 8'hF1, 8'hF2, 8'hF3);
    wr3(MD, 8'h01, 8'h02, 8'h03);
    wr(MR, 8'hFF);
    rd3(MD, 8'hF1, 8'hF2, 8'hF3, "R9 entry 255");
    rd3(MD, 8'h01, 8'h02, 8'h03, "R9 wrap to entry 0");

    // R8: overlay wrap and low-bit pointer load
    wr(OW, 8'h3F);
    wr3(OD, 8'h91, 8'h92, 8'h93);
    wr3(OD, 8'h94, 8'h95, 8'h96);
    wr(OR, 8'h0F);
    rd3(OD, 8'h91, 8'h92, 8'h93, "R8 overlay entry 15");
    rd3(OD, 8'h94, 8'h95, 8'h96, "R8 overlay wrap to 0");

    // R7: interleaved main and overlay sequences
    wr(MR, 8'h00);
    rd(MD, 8'h01, "R7 main red");
    wr(OR, 8'h00);
    rd(OD, 8'h94, "R7 overlay red");
    rd(MD, 8'h02, "R7 main green undisturbed");
    rd(OD, 8'h95, "R7 overlay green undisturbed");
    rd(MD, 8'h03, "R7 main blue");
    rd(OD, 8'h96, "R7 overlay blue");

    // R5: read data holds across idle and write cycles
    repeat (3) @(negedge clk);
    check("R5 hold over idle", bus_rdata, 8'h96);
    wr(4'h9, 8'h5A);
    @(negedge clk);
    check("R5 hold over write", bus_rdata, 8'h96);

    // R10: plain byte registers
    wr(4'hF, 8'hA5);
    wr(4'h3, 8'h3C);
    rd(4'h9, 8'h5A, "R10 scratch 0x9");
    rd(4'hF, 8'hA5, "R10 scratch 0xF");
    rd(4'h3, 8'h3C, "R10 scratch 0x3");
    rd(OW, 8'h3F, "R10 ovl wptr reg keeps full byte");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R5 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule